// File: doc/BRIEF.md
# Branch Fetch Steering Controller

This block picks the next fetch address for the first stage of a five-stage in-order integer pipeline, and decides what happens to the instruction slots around a branch. Each cycle the decode stage tells it whether the instruction it holds is a branch. For a branch it also gives the branch's own address, its computed target, whether the branch points backward, and whether it is a cancelling branch. Some cycles later a later stage reports the real outcome on a resolve strobe. Only one branch is outstanding at a time, and outcomes arrive in program order.

The handling policy comes from a 2-bit mode input, captured while reset is asserted. The four policies are:

- 0 (freeze): hold fetch until the branch resolves.
- 1 (sequential guess): keep fetching in sequence and squash on a taken branch.
- 2 (direction guess): redirect backward branches at decode, so taken is predicted and one fetch slot is lost, and treat forward branches as not taken.
- 3 (delay slot): the instruction right after the branch always executes. A cancelling branch that points backward is predicted taken, and its slot becomes a no-op when that prediction is wrong.

A discarded slot is shown to the pipeline as a bubble with its valid bit at 0. Two counters report how many branches were seen and how many were mispredicted.

Top module: `fetch_steer`

## Requirements
- R1: When no branch is being decoded and no outcome is being resolved, and fetch is not frozen, the fetch address advances by 4 each cycle.
- R2: The policy is the value of mode_i captured while rst_n is low (0 freeze, 1 sequential guess, 2 direction guess, 3 delay slot). Changing mode_i after reset has no effect.
- R3: Freeze mode: stall_o and flush_o are 1 from the decode cycle of a branch through its resolve cycle, and the fetch address holds. An outcome arriving L cycles after decode therefore costs L+1 bubbles. Fetch then continues at the target if taken, or repeats the fetch of branch address + 4 if not taken.
- R4: Sequential-guess mode: decoding a branch does not change the sequential fetch. A taken outcome raises flush_o for one cycle and redirects fetch to the target. A not-taken outcome has no effect.
- R5: Direction-guess mode: a backward branch sends the next fetch to its target and flushes the slot fetched in its decode cycle, a 1-cycle penalty. A forward branch leaves fetch sequential.
- R6: Direction-guess mode: a wrong guess raises flush_o at resolve. Fetch then goes to the target if taken, or to branch address + 4 if not taken.
- R7: Delay-slot mode: the slot fetched in the decode cycle is never flushed at decode. A cancelling backward branch sends the next fetch to its target with no bubble. Every other branch is predicted not taken. A wrong guess flushes and redirects to the target if taken, or to branch address + 8 if not taken.
- R8: annul_o, which marks the delay slot as a no-op, is 1 exactly in the resolve cycle of a wrongly predicted cancelling branch in delay-slot mode. A wrongly predicted non-cancelling branch flushes without annulling.
- R9: branch_cnt_o counts decoded branches and mispredict_cnt_o counts wrong guesses. Freeze mode never counts a wrong guess.
- R10: fetch_valid_o is 0 in every cycle where flush_o is 1, and 1 otherwise.
- R11: After reset the fetch address is RESET_PC (0x1000), both counters are 0, and stall_o, flush_o and annul_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; mode_i is captured while it is low |
| mode_i | input | 2 | Branch policy select |
| dec_valid_i | input | 1 | Decode stage holds a valid instruction |
| dec_branch_i | input | 1 | Decoded instruction is a branch |
| dec_backward_i | input | 1 | Branch offset is negative |
| dec_cancel_i | input | 1 | Branch is a cancelling branch |
| dec_pc_i | input | 32 | Address of the decoded instruction |
| dec_target_i | input | 32 | Computed branch target |
| res_valid_i | input | 1 | Outcome of the pending branch is valid |
| res_taken_i | input | 1 | Pending branch was taken |
| fetch_pc_o | output | 32 | Current fetch address |
| fetch_valid_o | output | 1 | Slot fetched this cycle is kept |
| flush_o | output | 1 | Discard the slot fetched this cycle and anything younger |
| annul_o | output | 1 | Turn the delay slot into a no-op |
| stall_o | output | 1 | Fetch is frozen |
| branch_cnt_o | output | 32 | Decoded branch count |
| mispredict_cnt_o | output | 32 | Wrong guess count |

## Verification
Each policy is driven through every combination of branch direction, cancelling flag, real outcome and a resolve latency of one to three cycles.

- The direction and cancelling inputs separate the policies: only direction-guess and delay-slot modes react to them, and only in their own ways.
- The outcome, crossed with the guess, separates correct guesses from the two kinds of recovery: the not-taken recovery address is +4 or +8 depending on mode.
- The latency sweep shows that the bubble count in freeze mode grows with the wait, while the other modes keep fetching in sequence.
- Changing mode_i right after reset shows that the captured policy stays in force.

// File: rtl/fetch_steer.sv
`timescale 1ns/1ps
module fetch_steer #(
  parameter int AW = 32,
  parameter int CW = 32,
  parameter logic [AW-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode_i,
  input  logic          dec_valid_i,
  input  logic          dec_branch_i,
  input  logic          dec_backward_i,
  input  logic          dec_cancel_i,
  input  logic [AW-1:0] dec_pc_i,
  input  logic [AW-1:0] dec_target_i,
  input  logic          res_valid_i,
  input  logic          res_taken_i,
  output logic [AW-1:0] fetch_pc_o,
  output logic          fetch_valid_o,
  output logic          flush_o,
  output logic          annul_o,
  output logic          stall_o,
  output logic [CW-1:0] branch_cnt_o,
  output logic [CW-1:0] mispredict_cnt_o
);
  localparam logic [1:0] MD_FREEZE = 2'd0;
  localparam logic [1:0] MD_SEQ    = 2'd1;
  localparam logic [1:0] MD_DIR    = 2'd2;
  localparam logic [1:0] MD_SLOT   = 2'd3;
  localparam logic [AW-1:0] STEP   = AW'(4);

  logic [1:0]    mode_q;
  logic [AW-1:0] pc_q, tgt_q, fall_q;
  logic          pend_q, pred_q, cancel_q, rdy_q;
  logic [CW-1:0] br_cnt_q, mis_cnt_q;

  logic          dec_br, guess_tk, res, wrong, early;
  logic [AW-1:0] pc_nxt;

  assign dec_br = dec_valid_i & dec_branch_i & ~pend_q;
  assign res    = res_valid_i & pend_q;

  always_comb begin
    case (mode_q)
      MD_DIR:  guess_tk = dec_backward_i;
      MD_SLOT: guess_tk = dec_cancel_i & dec_backward_i;
      default: guess_tk = 1'b0;
    endcase
  end

  assign early   = dec_br & guess_tk & (mode_q != MD_FREEZE);
  assign wrong   = res & (mode_q != MD_FREEZE) & (res_taken_i != pred_q);
  assign stall_o = (mode_q == MD_FREEZE) & (dec_br | pend_q);
  assign flush_o = stall_o | wrong | (early & (mode_q == MD_DIR));
  assign annul_o = wrong & cancel_q & (mode_q == MD_SLOT);
  assign fetch_valid_o = ~flush_o;

  always_comb begin
    if (res && mode_q == MD_FREEZE) pc_nxt = res_taken_i ? tgt_q : fall_q;
    else if (wrong)                 pc_nxt = res_taken_i ? tgt_q : fall_q;
    else if (stall_o)               pc_nxt = pc_q;
    else if (early)                 pc_nxt = dec_target_i;
    else                            pc_nxt = pc_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= mode_i;
      pc_q      <= RESET_PC;
      tgt_q     <= '0;
      fall_q    <= '0;
      pend_q    <= 1'b0;
      pred_q    <= 1'b0;
      cancel_q  <= 1'b0;
      rdy_q     <= 1'b0;
      br_cnt_q  <= '0;
      mis_cnt_q <= '0;
    end else begin
      rdy_q <= 1'b1;
      pc_q  <= pc_nxt;
      if (dec_br) begin
        pend_q   <= 1'b1;
        pred_q   <= guess_tk;
        cancel_q <= dec_cancel_i;
        tgt_q    <= dec_target_i;
        fall_q   <= dec_pc_i + ((mode_q == MD_SLOT) ? (STEP + STEP) : STEP);
        br_cnt_q <= br_cnt_q + CW'(1);
      end else if (res) begin
        pend_q <= 1'b0;
      end
      if (wrong) mis_cnt_q <= mis_cnt_q + CW'(1);
    end
  end

  assign fetch_pc_o       = pc_q;
  assign branch_cnt_o     = br_cnt_q;
  assign mispredict_cnt_o = mis_cnt_q;

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q && $past(!dec_br && !res_valid_i && !stall_o) |-> fetch_pc_o == $past(fetch_pc_o) + STEP); // R1
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q && $past(stall_o && !res_valid_i) |-> $stable(fetch_pc_o)); // R3
  AST_BWD_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q && $past(mode_q == MD_DIR && dec_br && dec_backward_i) |-> fetch_pc_o == $past(dec_target_i)); // R5
  AST_ANNUL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    annul_o |-> flush_o && mode_q == MD_SLOT && res_valid_i); // R8
  AST_MIS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q && (mispredict_cnt_o != $past(mispredict_cnt_o)) |-> $past(res_valid_i)); // R9
  AST_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |-> $stable(mode_q)); // R2
endmodule

// File: tb/fetch_steer_tb_top.sv
`timescale 1ns/1ps
module fetch_steer_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        dec_valid_i = 1'b0, dec_branch_i = 1'b0, dec_backward_i = 1'b0, dec_cancel_i = 1'b0;
  logic [31:0] dec_pc_i = '0, dec_target_i = '0;
  logic        res_valid_i = 1'b0, res_taken_i = 1'b0;
  logic [31:0] fetch_pc_o, branch_cnt_o, mispredict_cnt_o;
  logic        fetch_valid_o, flush_o, annul_o, stall_o;

  fetch_steer dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .dec_valid_i(dec_valid_i), .dec_branch_i(dec_branch_i), .dec_backward_i(dec_backward_i),
    .dec_cancel_i(dec_cancel_i), .dec_pc_i(dec_pc_i), .dec_target_i(dec_target_i),
    .res_valid_i(res_valid_i), .res_taken_i(res_taken_i),
    .fetch_pc_o(fetch_pc_o), .fetch_valid_o(fetch_valid_o), .flush_o(flush_o),
    .annul_o(annul_o), .stall_o(stall_o),
    .branch_cnt_o(branch_cnt_o), .mispredict_cnt_o(mispredict_cnt_o)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] epc, eprev, ebr, emis;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string rtag(input logic [1:0] m);
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0; mode_i = m;
    dec_valid_i = 0; dec_branch_i = 0; res_valid_i = 0; res_taken_i = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    mode_i = m + 2'd1; // R2: a later value must not change the policy
    #2;
    chk("R11 pc", fetch_pc_o, 32'h1000);
    chk("R11 branch count", branch_cnt_o, 0);
    chk("R11 mispredict count", mispredict_cnt_o, 0);
    chk("R11 stall", {31'd0, stall_o}, 0);
    chk("R11 flush", {31'd0, flush_o}, 0);
    chk("R11 annul", {31'd0, annul_o}, 0);
    epc = 32'h1000; ebr = 0; emis = 0;
  endtask

  task automatic run_case(input logic [1:0] m, input logic bwd, input logic cn,
                          input logic tk, input int lat);
    logic [31:0] bpc, tgt;
    logic pred, wrong, fl;
    dec_valid_i = 1; dec_branch_i = 0; res_valid_i = 0;
    #2;
    chk("R1 idle pc", fetch_pc_o, epc);
    chk("R1 idle flush", {31'd0, flush_o}, 0);
    @(posedge clk); #1;
    eprev = epc; epc = epc + 4;
    bpc = eprev;
    tgt = bwd ? bpc - 32'h40 : bpc + 32'h100;
    dec_branch_i = 1; dec_backward_i = bwd; dec_cancel_i = cn;
    dec_pc_i = bpc; dec_target_i = tgt;
    pred = (m == 2) ? bwd : (m == 3) ? (cn & bwd) : 1'b0;
    fl = (m == 0) || (m == 2 && bwd);
    #2;
    chk({rtag(m), " decode pc"}, fetch_pc_o, epc);
    chk("R2 decode stall follows captured mode", {31'd0, stall_o}, {31'd0, m == 0});
    chk({rtag(m), " decode flush"}, {31'd0, flush_o}, {31'd0, fl});
    chk("R10 decode valid", {31'd0, fetch_valid_o}, {31'd0, !fl});
    @(posedge clk); #1;
    ebr = ebr + 1;
    if (m == 0) epc = epc;
    else if (pred) epc = tgt;
    else epc = epc + 4;
    dec_branch_i = 0;
    for (int k = 1; k <= lat; k++) begin
      res_valid_i = (k == lat); res_taken_i = tk;
      wrong = (k == lat) && (m != 0) && (tk != pred);
      #2;
      chk({rtag(m), " wait pc"}, fetch_pc_o, epc);
      chk("R3 wait stall", {31'd0, stall_o}, {31'd0, m == 0});
      chk((m == 2) ? "R6 resolve flush" : {rtag(m), " resolve flush"},
          {31'd0, flush_o}, {31'd0, (m == 0) || wrong});
      chk("R8 annul", {31'd0, annul_o}, {31'd0, wrong && m == 3 && cn});
      chk("R10 valid", {31'd0, fetch_valid_o}, {31'd0, !((m == 0) || wrong)});
      @(posedge clk); #1;
      if (k == lat) begin
        if (m == 0) epc = tk ? tgt : bpc + 4;
        else if (wrong) epc = tk ? tgt : ((m == 3) ? bpc + 8 : bpc + 4);
        else epc = epc + 4;
        if (wrong) emis = emis + 1;
      end else if (m != 0) epc = epc + 4;
    end
    res_valid_i = 0;
    #2;
    chk((m == 2) ? "R6 recovery pc" : {rtag(m), " recovery pc"}, fetch_pc_o, epc);
    chk("R9 branch count", branch_cnt_o, ebr);
    chk("R9 mispredict count", mispredict_cnt_o, emis);
    @(posedge clk); #1;
    epc = epc + 4;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m));
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 2; c++)
          for (int t = 0; t < 2; t++)
            for (int l = 1; l <= 3; l++)
              run_case(2'(m), b[0], c[0], t[0], l);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule